// File: doc/BRIEF.md
# Luma AC 4x4 Dequantizer

This block turns a 4x4 block of signed 16-bit coefficient levels into dequantized coefficients. Each level is multiplied by a scale that depends on its position in the block and on a quantization parameter. A six-row table of three base scales is indexed by the parameter modulo 6. The chosen base scale is shifted left by the parameter divided by 6. The caller can also supply a DC value, which then takes the place of the result at position 0.

One block is accepted per cycle through a valid/ready input. The result appears on a registered output one cycle later. It stays there while the consumer holds its ready low. Entropy decoding and the inverse transform sit on either side of this block and are not part of it.

Top module: `luma_ac_dequant`

## Requirements
- R1: The parameter (after clamping) selects table row qp mod 6 and a left shift of qp div 6. The rows of (v0, v1, v2) are {10,16,13}, {11,18,14}, {13,20,16}, {14,23,18}, {16,25,20}, {18,29,23} for rows 0 to 5.
- R2: Coefficient k sits at bits [16k+15:16k] of the coefficient buses, at row k/4 and column k%4. Rows 0 and 2 use scales v0, v2, v0, v2 across columns 0 to 3.
- R3: Rows 1 and 3 use scales v2, v1, v2, v1 across columns 0 to 3.
- R4: Each output is the signed level times the shifted scale, truncated to its low 16 bits and read as signed. For example, a level of 100 at qp 36 gives -1536 at position 0.
- R5: When in_dc_en is 1 on an accepted block, output position 0 equals in_dc, whatever the level at position 0.
- R6: When in_dc_en is 0, output position 0 is its own scaled level.
- R7: A qp above 51 is treated as 51.
- R8: A block accepted at a clock edge (in_valid and in_ready both 1) appears on out_coef with out_valid 1 after that same edge. If nothing is accepted and the output is not stalled, out_valid is 0 after the next edge.
- R9: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_coef and out_valid hold their values.
- R10: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can accept input this cycle |
| in_coef | input | 256 | Sixteen signed 16-bit levels, position k at [16k+15:16k] |
| in_qp | input | 6 | Quantization parameter, values above 51 clamped |
| in_dc_en | input | 1 | Replace position 0 with in_dc |
| in_dc | input | 16 | Signed DC value |
| out_valid | output | 1 | Output block present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_coef | output | 256 | Sixteen signed 16-bit dequantized coefficients |

## Verification
Every result is due one cycle after acceptance. The bench drives each block on a falling edge, and the block is taken on the following rising edge. The bench compares all sixteen positions on the next falling edge, and one falling edge after that it checks that out_valid has dropped. In the stall test, out_ready is held low over several cycles. Across that window the bench checks that in_ready stays low and that the first block stays put. The waiting block is then expected on the falling edge after out_ready returns high.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int COEF_W  = 16;
  localparam int QP_MAX  = 51;
  localparam int ROW_W   = 3;
  localparam int SHIFT_W = 4;
  localparam int BASE_W  = 5;
  localparam int SCALE_W = BASE_W + (1 << (SHIFT_W - 1)) + 1;

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic [SCALE_W-1:0]       scale_t;
  typedef enum logic [1:0] {SEL_V0, SEL_V1, SEL_V2} scale_sel_e;

  // Six rows of three base scales, indexed by qp mod 6.
  function automatic logic [BASE_W-1:0] base_scale(input logic [ROW_W-1:0] row,
                                                   input scale_sel_e sel);
    logic [BASE_W-1:0] v0, v1, v2;
    case (row)
      3'd0: begin v0 = 5'd10; v1 = 5'd16; v2 = 5'd13; end
      3'd1: begin v0 = 5'd11; v1 = 5'd18; v2 = 5'd14; end
      3'd2: begin v0 = 5'd13; v1 = 5'd20; v2 = 5'd16; end
      3'd3: begin v0 = 5'd14; v1 = 5'd23; v2 = 5'd18; end
      3'd4: begin v0 = 5'd16; v1 = 5'd25; v2 = 5'd20; end
      default: begin v0 = 5'd18; v1 = 5'd29; v2 = 5'd23; end
    endcase
    case (sel)
      SEL_V0:  return v0;
      SEL_V1:  return v1;
      default: return v2;
    endcase
  endfunction

  // Position class: even row and even column -> v0, both odd -> v1, else v2.
  function automatic scale_sel_e pos_sel(input int r, input int c);
    if ((r % 2) != (c % 2)) return SEL_V2;
    return ((r % 2) == 0) ? SEL_V0 : SEL_V1;
  endfunction

  function automatic logic [5:0] clamp_qp(input logic [5:0] qp);
    return (qp > 6'(QP_MAX)) ? 6'(QP_MAX) : qp;
  endfunction

  // Divide by 6 via reciprocal multiply; exact for 0..51.
  function automatic logic [SHIFT_W-1:0] qp_div6(input logic [5:0] qp);
    logic [11:0] prod;
    prod = 12'(qp) * 12'd43;
    return SHIFT_W'(prod >> 8);
  endfunction

  function automatic logic [ROW_W-1:0] qp_mod6(input logic [5:0] qp,
                                               input logic [SHIFT_W-1:0] q6);
    logic [5:0] rem;
    rem = qp - 6'(q6) * 6'd6;
    return rem[ROW_W-1:0];
  endfunction

  // Signed level times unsigned scale, truncated to the coefficient width.
  function automatic coef_t scale_coef(input coef_t lvl, input scale_t s);
    logic signed [COEF_W+SCALE_W:0] prod;
    prod = (COEF_W+SCALE_W+1)'(lvl) * $signed({1'b0, s});
    return prod[COEF_W-1:0];
  endfunction
endpackage

// File: rtl/dq_qp_decode.sv
module dq_qp_decode
  import dq_pkg::*;
#(
  parameter int QP_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [QP_W-1:0]      qp,
  output logic [ROW_W-1:0]     row,
  output logic [SHIFT_W-1:0]   shift
);
  logic [5:0] qp_clamped;

  always_comb begin
    qp_clamped = clamp_qp(6'(qp));
    shift      = qp_div6(qp_clamped);
    row        = qp_mod6(qp_clamped, shift);
  end

  // R1 / R7: decoded indices stay inside the table and shift range.
  always_ff @(posedge clk) begin
    if (rst_n) begin
      p_decode_range_r7: assert (row < 3'd6 && shift <= 4'd8)
        else $error("qp decode out of range");
    end
  end
endmodule

// File: rtl/dq_scale_select.sv
module dq_scale_select
  import dq_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int NUM_POS = ROWS * COLS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROW_W-1:0]     row,
  input  logic [SHIFT_W-1:0]   shift,
  output scale_t               scale [NUM_POS]
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam scale_sel_e SEL = pos_sel(r, c);
      always_comb begin
        scale[r*COLS+c] = scale_t'(base_scale(row, SEL)) << shift;
      end
    end
  end

  // R2: even-row positions share the pattern v0 v2 v0 v2.
  p_even_rows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scale[0] == scale[2] && scale[0] == scale[8] && scale[1] == scale[11])
    else $error("even-row scale pattern broken");

  // R3: odd-row positions share v2 v1 v2 v1, with v2 common to even rows.
  p_odd_rows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scale[5] == scale[15] && scale[4] == scale[1] && scale[6] == scale[12])
    else $error("odd-row scale pattern broken");
endmodule

// File: rtl/dq_lane.sv
module dq_lane
  import dq_pkg::*;
#(
  parameter bit IS_DC = 1'b0
) (
  input  coef_t   lvl,
  input  scale_t  scale,
  input  logic    dc_en,
  input  coef_t   dc,
  output coef_t   result
);
  coef_t scaled;

  always_comb scaled = scale_coef(lvl, scale);

  if (IS_DC) begin : g_dc
    always_comb result = dc_en ? dc : scaled;
  end else begin : g_ac
    logic unused_dc;
    always_comb begin
      unused_dc = dc_en ^ (^dc);
      result    = scaled;
    end
  end
endmodule

// File: rtl/luma_ac_dequant.sv
module luma_ac_dequant
  import dq_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int QP_W = 6,
  localparam int NUM_POS = ROWS * COLS,
  localparam int BUS_W   = NUM_POS * COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BUS_W-1:0]  in_coef,
  input  logic [QP_W-1:0]   in_qp,
  input  logic              in_dc_en,
  input  logic [COEF_W-1:0] in_dc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BUS_W-1:0]  out_coef
);
  logic [ROW_W-1:0]   row;
  logic [SHIFT_W-1:0] shift;
  scale_t             scale [NUM_POS];
  logic [BUS_W-1:0]   next_coef;
  logic               accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  dq_qp_decode #(.QP_W(QP_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .qp(in_qp), .row(row), .shift(shift)
  );

  dq_scale_select #(.ROWS(ROWS), .COLS(COLS)) u_scale (
    .clk(clk), .rst_n(rst_n), .row(row), .shift(shift), .scale(scale)
  );

  for (genvar k = 0; k < NUM_POS; k++) begin : g_lane
    coef_t lane_out;
    dq_lane #(.IS_DC(k == 0)) u_lane (
      .lvl(coef_t'(in_coef[k*COEF_W +: COEF_W])),
      .scale(scale[k]),
      .dc_en(in_dc_en),
      .dc(coef_t'(in_dc)),
      .result(lane_out)
    );
    assign next_coef[k*COEF_W +: COEF_W] = lane_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_coef  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_coef <= next_coef;
    end
  end

  // R8: an accepted block is on the output after the edge.
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid) else $error("accepted block not presented");

  // R8: with no acceptance and no stall, the output empties.
  p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (out_ready || !out_valid) |=> !out_valid)
    else $error("out_valid without an accepted block");

  // R9: a stalled output holds.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_coef))
    else $error("stalled output changed");

  // R5: a supplied DC value lands at position 0.
  p_dc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_dc_en |=> out_coef[COEF_W-1:0] == $past(in_dc))
    else $error("DC override missing");
endmodule

// File: tb/test_luma_ac_dequant.sv
module test_luma_ac_dequant;
  localparam int NP = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_coef = '0;
  logic [5:0]   in_qp = '0;
  logic         in_dc_en = 1'b0;
  logic [15:0]  in_dc = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_coef;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  luma_ac_dequant i_luma_ac_dequant (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_qp(in_qp), .in_dc_en(in_dc_en), .in_dc(in_dc),
    .out_valid(out_valid), .out_ready(out_ready), .out_coef(out_coef)
  );

  typedef struct packed {
    logic [5:0]  qp;
    logic        dc_en;
    logic [15:0] dc;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  1'b0, 16'd0,     8'd1},
    '{6'd1,  1'b0, 16'd0,     8'd2},
    '{6'd5,  1'b0, 16'd0,     8'd3},
    '{6'd6,  1'b0, 16'd0,     8'd4},
    '{6'd17, 1'b0, 16'd0,     8'd5},
    '{6'd28, 1'b1, 16'd1234,  8'd6},
    '{6'd33, 1'b0, 16'd0,     8'd7},
    '{6'd45, 1'b1, 16'hFF00,  8'd8},
    '{6'd51, 1'b0, 16'd0,     8'd9},
    '{6'd52, 1'b0, 16'd0,     8'd10},
    '{6'd63, 1'b1, 16'h8000,  8'd11},
    '{6'd22, 1'b1, 16'd7,     8'd12}
  };

  function automatic logic [15:0] gen_lvl(input int seed, input int k);
    int v;
    v = (seed * 373 + k * 1111 - 9000) % 20000;
    return 16'(v);
  endfunction

  // Reference model built from the requirements.
  function automatic logic [15:0] model(input logic [15:0] lvl, input int qp_in,
                                        input bit dc_en, input logic [15:0] dc,
                                        input int k);
    int q, m, d, r, c, v0, v1, v2, v, p;
    if (k == 0 && dc_en) return dc;
    q = (qp_in > 51) ? 51 : qp_in;
    m = q % 6;
    d = q / 6;
    case (m)
      0: begin v0 = 10; v1 = 16; v2 = 13; end
      1: begin v0 = 11; v1 = 18; v2 = 14; end
      2: begin v0 = 13; v1 = 20; v2 = 16; end
      3: begin v0 = 14; v1 = 23; v2 = 18; end
      4: begin v0 = 16; v1 = 25; v2 = 20; end
      default: begin v0 = 18; v1 = 29; v2 = 23; end
    endcase
    r = k / 4;
    c = k % 4;
    if (r == 0 || r == 2) v = (c == 0 || c == 2) ? v0 : v2;
    else                  v = (c == 0 || c == 2) ? v2 : v1;
    p = int'($signed(lvl)) * (v * (1 << d));
    return 16'(p);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic load(input int qp, input bit dce, input logic [15:0] dc,
                      input int seed);
    in_qp    = 6'(qp);
    in_dc_en = dce;
    in_dc    = dc;
    for (int k = 0; k < NP; k++) in_coef[k*16 +: 16] = gen_lvl(seed, k);
  endtask

  function automatic logic [255:0] expect_bus(input int qp, input bit dce,
                                              input logic [15:0] dc, input int seed);
    logic [255:0] b;
    for (int k = 0; k < NP; k++) b[k*16 +: 16] = model(gen_lvl(seed, k), qp, dce, dc, k);
    return b;
  endfunction

  // Drive one block, compare it one cycle later, then expect out_valid low.
  task automatic run_vec(input int qp, input bit dce, input logic [15:0] dc,
                         input int seed, input string tag);
    logic [255:0] e;
    int bad;
    e = expect_bus(qp, dce, dc, seed);
    @(negedge clk);
    load(qp, dce, dc, seed);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    bad = 0;
    for (int k = 0; k < NP; k++) begin
      if (out_coef[k*16 +: 16] !== e[k*16 +: 16]) begin
        bad++;
        $display("FAIL %s qp=%0d pos=%0d actual=%0h expected=%0h", tag, qp, k,
                 out_coef[k*16 +: 16], e[k*16 +: 16]);
      end
    end
    checks++;
    if (bad != 0) fails++;
    check(out_valid === 1'b1, "R8 out_valid after accept", 32'(out_valid), 32'd1);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 out_valid drops when idle", 32'(out_valid), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [255:0] ea, eb;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid === 1'b0, "R10 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R10 out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready === 1'b1, "R10 in_ready after reset", 32'(in_ready), 32'd1);

    // R1 R2 R3 R5 R6 R7: table walk
    for (int i = 0; i < NV; i++)
      run_vec(VECS[i].qp, VECS[i].dc_en, VECS[i].dc, VECS[i].seed, "R1/R2/R3/R5/R6/R7 vector");

    // R4: directed truncation case, level 100 at qp 36, position 0
    @(negedge clk);
    in_coef = '0;
    for (int k = 0; k < NP; k++) in_coef[k*16 +: 16] = 16'd100;
    in_qp = 6'd36; in_dc_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_coef[15:0] === 16'hFA00, "R4 wrap at position 0", 32'(out_coef[15:0]), 32'hFA00);
    // R3: position 5 (row 1, col 1) uses v1: 100*16<<6 = 102400 -> 0x9000
    check(out_coef[5*16 +: 16] === 16'h9000, "R3 v1 at position 5",
          32'(out_coef[5*16 +: 16]), 32'h9000);
    // R2: position 2 uses v0: 100*640 -> 0xFA00
    check(out_coef[2*16 +: 16] === 16'hFA00, "R2 v0 at position 2",
          32'(out_coef[2*16 +: 16]), 32'hFA00);

    // R4 extremes
    run_vec(51, 1'b0, 16'd0, 200, "R4 extreme seed");
    @(negedge clk);
    for (int k = 0; k < NP; k++) in_coef[k*16 +: 16] = 16'h8000;
    in_qp = 6'd40; in_dc_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < NP; k++) begin
      logic [15:0] ex;
      ex = model(16'h8000, 40, 1'b0, 16'd0, k);
      check(out_coef[k*16 +: 16] === ex, "R4 most negative level",
            32'(out_coef[k*16 +: 16]), 32'(ex));
    end

    // R6: DC value present on the bus but not enabled
    ea = expect_bus(13, 1'b0, 16'h1111, 21);
    @(negedge clk);
    load(13, 1'b0, 16'h1111, 21);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_coef[15:0] === ea[15:0], "R6 DC ignored when disabled",
          32'(out_coef[15:0]), 32'(ea[15:0]));

    // R9: stall holds the first block and refuses the second
    ea = expect_bus(9, 1'b1, 16'h0042, 31);
    eb = expect_bus(44, 1'b0, 16'h0, 32);
    @(negedge clk);
    out_ready = 1'b0;
    load(9, 1'b1, 16'h0042, 31);
    in_valid = 1'b1;
    @(negedge clk);
    load(44, 1'b0, 16'h0, 32);
    check(out_coef === ea, "R9 first block presented", 32'(out_coef[31:0]), 32'(ea[31:0]));
    check(in_ready === 1'b0, "R9 in_ready low while stalled", 32'(in_ready), 32'd0);
    repeat (3) @(negedge clk);
    check(out_coef === ea && out_valid === 1'b1, "R9 output held during stall",
          32'(out_coef[31:0]), 32'(ea[31:0]));
    check(in_ready === 1'b0, "R9 in_ready still low", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_coef === eb && out_valid === 1'b1, "R9 second block after release",
          32'(out_coef[31:0]), 32'(eb[31:0]));
    @(negedge clk);
    check(out_valid === 1'b0, "R8 empty after release", 32'(out_valid), 32'd0);

    // R8: back-to-back blocks every cycle
    ea = expect_bus(3, 1'b0, 16'h0, 41);
    eb = expect_bus(30, 1'b1, 16'hABCD, 42);
    @(negedge clk);
    load(3, 1'b0, 16'h0, 41);
    in_valid = 1'b1;
    @(negedge clk);
    check(out_coef === ea, "R8 back-to-back first", 32'(out_coef[31:0]), 32'(ea[31:0]));
    load(30, 1'b1, 16'hABCD, 42);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_coef === eb, "R8 back-to-back second", 32'(out_coef[31:0]), 32'(eb[31:0]));

    finish_run();
  end
endmodule